// File: doc/BRIEF.md
# Event-Triggered Peripheral FIFO Writer

This block is the transmit end of a peripheral DMA channel. Bytes arrive one per cycle on a valid/ready stream and collect in a small internal buffer. Each time a peripheral raises a DMA request, the block services one event: it packs buffered bytes little-endian into elements of a configured size and issues them, one element per cycle, as writes on a simple bus that carries the element, its transfer size and the index of the target peripheral FIFO.

Two ways of targeting are supported. In plain mode every element of an event goes to a single FIFO index, and the event holds `cfg_y` elements. In list mode a short list of FIFO indices is walked from first to last entry, and the whole list is walked `cfg_y` times per event. A transfer-size override forces every write to report four bytes on a 32-bit peripheral port, for peripherals that accept only word accesses. An event is admitted only once all of its bytes are buffered, so an event, once started, never stalls for data.

Top module: `etx_fifo_writer`

## Requirements
- R1: After reset `wr_valid`, `ev_ack`, `st_in_event`, `st_data`, `st_remain` and `st_cfg_err` are all zero.
- R2: `cfg_esize` codes 0,1,2,3,4 select elements of 1,2,3,4,8 bytes; element byte k comes from the k-th oldest buffered byte and sits at `wr_data[8k+7:8k]`; bytes of `wr_data` above the element are zero; `wr_size` gives the element size in bytes.
- R3: In plain mode (`cfg_list_mode`=0) one event issues exactly `cfg_y` writes, all to FIFO index `cfg_fifo`.
- R4: In list mode the list holds `cfg_list_last`+1 entries, entry i at `cfg_list[i*IDX_W +: IDX_W]`; one event issues `cfg_y` passes over entries 0..last in order, `cfg_y`×(last+1) writes in total.
- R5: With `cfg_acc32`=1 and a 4-byte bus (`BUS_BYTES`=4), `wr_size` is 4 for every write whatever the element size; data packing is unchanged.
- R6: `ev_ack` pulses for one cycle, while `ev_req` is high, exactly when no event is in progress, no config error is present and `st_xdata` is high; `st_in_event` rises the cycle after an acknowledge of a non-empty event and stays high until its last write completes.
- R7: `st_data` is high when the buffer holds at least one byte; `st_xdata` is high when it holds at least element size × elements per event bytes.
- R8: `st_remain` equals the number of writes still to issue for the current event and is zero when idle.
- R9: `wr_valid` is high throughout an event; a write completes on a cycle where `wr_valid` and `wr_ready` are both high; with `wr_ready` low the write holds its data, size and index.
- R10: A reserved size code (5, 6, 7) sets `st_cfg_err` the next cycle; it stays set until reset and blocks acknowledges and writes.
- R11: An event with `cfg_y`=0 is acknowledged and completes without any write.
- R12: `in_ready` is low exactly when the buffer holds `BUF_BYTES` bytes; the buffer never overflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Buffer can accept a byte |
| in_byte | input | 8 | Input byte |
| ev_req | input | 1 | Peripheral DMA event pending (level) |
| ev_ack | output | 1 | One event taken for service |
| cfg_list_mode | input | 1 | 0 = single FIFO, 1 = FIFO list |
| cfg_esize | input | 3 | Element size code |
| cfg_acc32 | input | 1 | Force 4-byte transfer size on a 32-bit port |
| cfg_y | input | 12 | Elements (plain) or list passes (list) per event |
| cfg_fifo | input | IDX_W | FIFO index in plain mode |
| cfg_list_last | input | LIST_AW | Index of the last list entry |
| cfg_list | input | LIST_MAX*IDX_W | FIFO index list, entry 0 in the low bits |
| wr_valid | output | 1 | Write request |
| wr_ready | input | 1 | Bus accepts the write |
| wr_data | output | 64 | Packed element, zero above the element |
| wr_size | output | 4 | Transfer size in bytes |
| wr_fifo | output | IDX_W | Target FIFO index |
| st_in_event | output | 1 | An event is being serviced |
| st_data | output | 1 | Buffer not empty |
| st_xdata | output | 1 | A whole event's bytes are buffered |
| st_remain | output | 16 | Writes left in the current event |
| st_cfg_err | output | 1 | Sticky reserved-size error |

## Verification
The embedded properties take for granted that configuration stays still while an event is in progress, that a reserved size code is never introduced in the middle of an event, and that one event never needs more bytes than the buffer holds. The stimulus changes configuration only while the reference model reports the block idle with `ev_req` low, sizes every event to at most 64 bytes, and introduces the reserved code only after the last event has drained. Bus back-pressure is varied by a random `wr_ready` in some phases and held high in others, so writes are compared against the model both when they complete at once and when they stall.

// File: rtl/etx_pkg.sv
package etx_pkg;

    localparam int ELEM_MAX_BYTES = 8;
    localparam int ELEM_W         = ELEM_MAX_BYTES * 8;

    typedef enum logic [2:0] {
        ES_8  = 3'd0,
        ES_16 = 3'd1,
        ES_24 = 3'd2,
        ES_32 = 3'd3,
        ES_64 = 3'd4
    } esize_e;

    // Bytes per element; zero marks a reserved code.
    function automatic logic [3:0] esize_bytes(input logic [2:0] code);
        case (code)
            ES_8:    return 4'd1;
            ES_16:   return 4'd2;
            ES_24:   return 4'd3;
            ES_32:   return 4'd4;
            ES_64:   return 4'd8;
            default: return 4'd0;
        endcase
    endfunction

endpackage

// File: rtl/etx_bytebuf.sv
module etx_bytebuf #(
    parameter int DEPTH = 64,
    parameter int PTR_W = $clog2(DEPTH),
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      push,
    input  logic [7:0]                push_byte,
    input  logic                      pop,
    input  logic [3:0]                pop_n,
    output logic [CNT_W-1:0]          count,
    output logic [etx_pkg::ELEM_W-1:0] peek
);
    typedef struct packed {
        logic [PTR_W-1:0] wptr;
        logic [PTR_W-1:0] rptr;
        logic [CNT_W-1:0] cnt;
    } bstate_t;

    bstate_t    s_d, s_q;
    logic [7:0] mem_q [DEPTH];

    always_comb begin
        s_d = s_q;
        if (push) s_d.wptr = s_q.wptr + PTR_W'(1);
        if (pop)  s_d.rptr = s_q.rptr + PTR_W'(pop_n);
        s_d.cnt = s_q.cnt + CNT_W'(push) - (pop ? CNT_W'(pop_n) : CNT_W'(0));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem_q[s_q.wptr] <= push_byte;
    end

    for (genvar k = 0; k < etx_pkg::ELEM_MAX_BYTES; k++) begin : g_peek
        assign peek[k*8 +: 8] = mem_q[PTR_W'(s_q.rptr + PTR_W'(k))];
    end

    assign count = s_q.cnt;

    // R12
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CNT_W'(DEPTH));

    // R9
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (s_q.cnt >= CNT_W'(pop_n)));

endmodule

// File: rtl/etx_sizer.sv
module etx_sizer #(
    parameter int BUS_BYTES = 4
) (
    input  logic [2:0] esize,
    input  logic       acc32,
    output logic [3:0] elem_bytes,
    output logic [3:0] xfer_bytes,
    output logic       reserved
);
    localparam bit NARROW_PORT = (BUS_BYTES == 4);

    always_comb begin
        elem_bytes = etx_pkg::esize_bytes(esize);
        reserved   = (elem_bytes == 4'd0);
        xfer_bytes = (acc32 && NARROW_PORT) ? 4'd4 : elem_bytes;
    end

endmodule

// File: rtl/etx_seq.sv
module etx_seq #(
    parameter int IDX_W    = 4,
    parameter int LIST_MAX = 4,
    parameter int Y_W      = 12,
    parameter int CNT_W    = 7,
    parameter int LIST_AW  = $clog2(LIST_MAX)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_list_mode,
    input  logic [Y_W-1:0]            cfg_y,
    input  logic [IDX_W-1:0]          cfg_fifo,
    input  logic [LIST_AW-1:0]        cfg_list_last,
    input  logic [LIST_MAX*IDX_W-1:0] cfg_list,
    input  logic [3:0]                elem_bytes,
    input  logic                      reserved,
    input  logic [CNT_W-1:0]          buf_count,
    input  logic                      ev_req,
    output logic                      ev_ack,
    output logic                      wr_valid,
    input  logic                      wr_ready,
    output logic                      wr_fire,
    output logic [IDX_W-1:0]          wr_fifo,
    output logic                      st_in_event,
    output logic                      st_xdata,
    output logic [15:0]               st_remain,
    output logic                      st_cfg_err
);
    typedef struct packed {
        logic               inev;
        logic               err;
        logic [15:0]        remain;
        logic [LIST_AW-1:0] lidx;
    } sstate_t;

    sstate_t     s_d, s_q;
    logic [15:0] total;
    logic [19:0] need;
    logic        err_now;

    always_comb begin
        total    = cfg_list_mode ? 16'(cfg_y) * (16'(cfg_list_last) + 16'd1)
                                 : 16'(cfg_y);
        need     = 20'(total) * 20'(elem_bytes);
        st_xdata = (20'(buf_count) >= need);
        err_now  = s_q.err | reserved;
        ev_ack   = !s_q.inev && ev_req && st_xdata && !err_now;
        wr_valid = s_q.inev && !s_q.err;
        wr_fire  = wr_valid && wr_ready;

        s_d     = s_q;
        s_d.err = err_now;
        if (err_now) begin
            s_d.inev   = 1'b0;
            s_d.remain = '0;
        end else if (ev_ack) begin
            s_d.inev   = (total != 16'd0);
            s_d.remain = total;
            s_d.lidx   = '0;
        end else if (wr_fire) begin
            s_d.remain = s_q.remain - 16'd1;
            s_d.lidx   = (!cfg_list_mode || s_q.lidx == cfg_list_last)
                         ? '0 : s_q.lidx + LIST_AW'(1);
            if (s_q.remain == 16'd1) s_d.inev = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign wr_fifo     = cfg_list_mode ? cfg_list[s_q.lidx*IDX_W +: IDX_W] : cfg_fifo;
    assign st_in_event = s_q.inev;
    assign st_remain   = s_q.remain;
    assign st_cfg_err  = s_q.err;

    // R8
    remain_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && s_q.remain > 16'd1 && !reserved) |=>
            (st_remain == $past(s_q.remain) - 16'd1) && st_in_event);

    // R6
    ack_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_ack && total != 16'd0) |=> st_in_event && (st_remain == $past(total)));

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_cfg_err |=> st_cfg_err);

    // R4
    list_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.inev && cfg_list_mode) |-> (s_q.lidx <= cfg_list_last));

endmodule

// File: rtl/etx_fifo_writer.sv
module etx_fifo_writer #(
    parameter int BUF_BYTES = 64,
    parameter int BUS_BYTES = 4,
    parameter int IDX_W     = 4,
    parameter int LIST_MAX  = 4,
    parameter int Y_W       = 12,
    parameter int LIST_AW   = $clog2(LIST_MAX)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    output logic                      in_ready,
    input  logic [7:0]                in_byte,
    input  logic                      ev_req,
    output logic                      ev_ack,
    input  logic                      cfg_list_mode,
    input  logic [2:0]                cfg_esize,
    input  logic                      cfg_acc32,
    input  logic [Y_W-1:0]            cfg_y,
    input  logic [IDX_W-1:0]          cfg_fifo,
    input  logic [LIST_AW-1:0]        cfg_list_last,
    input  logic [LIST_MAX*IDX_W-1:0] cfg_list,
    output logic                      wr_valid,
    input  logic                      wr_ready,
    output logic [63:0]               wr_data,
    output logic [3:0]                wr_size,
    output logic [IDX_W-1:0]          wr_fifo,
    output logic                      st_in_event,
    output logic                      st_data,
    output logic                      st_xdata,
    output logic [15:0]               st_remain,
    output logic                      st_cfg_err
);
    localparam int CNT_W = $clog2(BUF_BYTES + 1);

    logic [CNT_W-1:0]           count;
    logic [etx_pkg::ELEM_W-1:0] peek;
    logic [3:0]                 elem_bytes;
    logic                       reserved;
    logic                       wr_fire;
    logic                       push;

    assign push     = in_valid && in_ready;
    assign in_ready = (count != CNT_W'(BUF_BYTES));
    assign st_data  = (count != '0);

    etx_bytebuf #(.DEPTH(BUF_BYTES)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_byte (in_byte),
        .pop       (wr_fire),
        .pop_n     (elem_bytes),
        .count     (count),
        .peek      (peek)
    );

    etx_sizer #(.BUS_BYTES(BUS_BYTES)) u_size (
        .esize      (cfg_esize),
        .acc32      (cfg_acc32),
        .elem_bytes (elem_bytes),
        .xfer_bytes (wr_size),
        .reserved   (reserved)
    );

    etx_seq #(
        .IDX_W(IDX_W), .LIST_MAX(LIST_MAX), .Y_W(Y_W), .CNT_W(CNT_W)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_list_mode (cfg_list_mode),
        .cfg_y         (cfg_y),
        .cfg_fifo      (cfg_fifo),
        .cfg_list_last (cfg_list_last),
        .cfg_list      (cfg_list),
        .elem_bytes    (elem_bytes),
        .reserved      (reserved),
        .buf_count     (count),
        .ev_req        (ev_req),
        .ev_ack        (ev_ack),
        .wr_valid      (wr_valid),
        .wr_ready      (wr_ready),
        .wr_fire       (wr_fire),
        .wr_fifo       (wr_fifo),
        .st_in_event   (st_in_event),
        .st_xdata      (st_xdata),
        .st_remain     (st_remain),
        .st_cfg_err    (st_cfg_err)
    );

    for (genvar k = 0; k < etx_pkg::ELEM_MAX_BYTES; k++) begin : g_pack
        assign wr_data[k*8 +: 8] = (4'(k) < elem_bytes) ? peek[k*8 +: 8] : 8'h00;
    end

    // R12
    in_ready_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready && !wr_fire) |=> !in_ready);

endmodule

// File: tb/tb_etx_fifo_writer.sv
`timescale 1ns/1ps
module tb_etx_fifo_writer;
    localparam int DEPTH = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_byte = '0;
    logic        ev_req = 1'b0;
    logic        ev_ack;
    logic        cfg_list_mode = 1'b0;
    logic [2:0]  cfg_esize = '0;
    logic        cfg_acc32 = 1'b0;
    logic [11:0] cfg_y = '0;
    logic [3:0]  cfg_fifo = '0;
    logic [1:0]  cfg_list_last = '0;
    logic [15:0] cfg_list = '0;
    logic        wr_valid;
    logic        wr_ready = 1'b1;
    logic [63:0] wr_data;
    logic [3:0]  wr_size;
    logic [3:0]  wr_fifo;
    logic        st_in_event, st_data, st_xdata, st_cfg_err;
    logic [15:0] st_remain;

    always #2.5 clk = ~clk;

    etx_fifo_writer dut (.*);

    typedef struct { logic [63:0] data; int size; int fifo; } wr_t;

    int n_checks = 0;
    int n_err    = 0;
    int m_acks   = 0;
    bit m_inev   = 0;
    bit m_err    = 0;
    bit rnd_ready = 0;
    logic [7:0] q[$];
    wr_t expq[$];

    function automatic int bytes_of(input logic [2:0] c);
        case (c)
            3'd0: return 1;
            3'd1: return 2;
            3'd2: return 3;
            3'd3: return 4;
            3'd4: return 8;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model, evaluated between edges for the coming edge.
    always @(negedge clk) begin
        if (rst_n) begin
            int esz, total, need, len;
            bit errnow, exp_ack, exp_wv;
            esz    = bytes_of(cfg_esize);
            len    = int'(cfg_list_last) + 1;
            total  = cfg_list_mode ? int'(cfg_y) * len : int'(cfg_y);
            need   = total * esz;
            errnow = m_err || (esz == 0);

            chk(in_ready == (q.size() < DEPTH), "R12 in_ready", in_ready, q.size() < DEPTH);
            chk(st_data == (q.size() != 0), "R7 st_data", st_data, q.size() != 0);
            chk(st_xdata == (q.size() >= need), "R7 st_xdata", st_xdata, q.size() >= need);
            chk(st_in_event == m_inev, "R6 st_in_event", st_in_event, m_inev);
            chk(st_remain == 16'(expq.size()), "R8 st_remain", st_remain, expq.size());
            chk(st_cfg_err == m_err, "R10 st_cfg_err", st_cfg_err, m_err);

            exp_ack = !m_inev && ev_req && (q.size() >= need) && !errnow;
            chk(ev_ack == exp_ack, "R6 ev_ack", ev_ack, exp_ack);

            exp_wv = m_inev && !m_err;
            chk(wr_valid == exp_wv, "R9 wr_valid", wr_valid, exp_wv);
            if (exp_wv && expq.size() > 0) begin
                chk(wr_data == expq[0].data, "R2 wr_data", wr_data, expq[0].data);
                chk(wr_size == 4'(expq[0].size), "R2/R5 wr_size", wr_size, expq[0].size);
                chk(wr_fifo == 4'(expq[0].fifo), "R3/R4 wr_fifo", wr_fifo, expq[0].fifo);
                if (wr_ready) begin
                    for (int i = 0; i < esz; i++) void'(q.pop_front());
                    void'(expq.pop_front());
                    if (expq.size() == 0) m_inev = 0;
                end
            end

            if (errnow) begin
                m_err = 1;
                m_inev = 0;
                expq.delete();
            end else if (exp_ack) begin
                int off;
                off = 0;
                for (int j = 0; j < total; j++) begin
                    wr_t w;
                    w.data = '0;
                    for (int b = 0; b < esz; b++) w.data[b*8 +: 8] = q[off + b];
                    off += esz;
                    w.size = (cfg_acc32) ? 4 : esz;
                    w.fifo = cfg_list_mode ? int'(cfg_list[(j % len)*4 +: 4]) : int'(cfg_fifo);
                    expq.push_back(w);
                end
                m_inev = (total != 0);
                m_acks++;
            end

            if (in_valid && in_ready) q.push_back(in_byte);
        end
    end

    // Bus back-pressure driver.
    initial begin
        forever begin
            @(posedge clk);
            #1 wr_ready = rnd_ready ? 1'($urandom_range(0, 1)) : 1'b1;
        end
    end

    task automatic push_n(input int n, input logic [7:0] base);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
            in_valid = 1'b1;
            in_byte  = base + 8'(i * 7);
            do @(negedge clk); while (!in_ready);
        end
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic wait_idle();
        do @(posedge clk); while (m_inev);
        #1;
    endtask

    task automatic run_ev(input int k);
        int tgt;
        tgt = m_acks + k;
        @(posedge clk);
        #1 ev_req = 1'b1;
        while (m_acks < tgt) @(posedge clk);
        #1 ev_req = 1'b0;
        wait_idle();
    endtask

    task automatic set_cfg(input bit lm, input logic [2:0] es, input bit a32,
                           input int y, input int fifo, input int last, input logic [15:0] lst);
        @(posedge clk);
        #1;
        cfg_list_mode = lm;
        cfg_esize     = es;
        cfg_acc32     = a32;
        cfg_y         = 12'(y);
        cfg_fifo      = 4'(fifo);
        cfg_list_last = 2'(last);
        cfg_list      = lst;
    endtask

    initial begin
        int tgt;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(wr_valid == 0 && ev_ack == 0, "R1 reset wr_valid/ev_ack", {wr_valid, ev_ack}, 0);
        chk(st_in_event == 0 && st_data == 0, "R1 reset st_in_event/st_data", {st_in_event, st_data}, 0);
        chk(st_remain == 0 && st_cfg_err == 0, "R1 reset st_remain/st_cfg_err", {st_remain, st_cfg_err}, 0);

        // R3 R2: plain mode, 32-bit elements
        set_cfg(0, 3'd3, 0, 3, 5, 0, 16'h0);
        push_n(12, 8'h10);
        run_ev(1);

        // R2: 24-bit elements with random back-pressure (R9)
        rnd_ready = 1;
        set_cfg(0, 3'd2, 0, 2, 9, 0, 16'h0);
        push_n(6, 8'h40);
        run_ev(1);

        // R2: 64-bit elements
        set_cfg(0, 3'd4, 0, 2, 2, 0, 16'h0);
        push_n(16, 8'h81);
        run_ev(1);

        // R4: list mode, 4 entries 3,1,2,0, two passes, 16-bit elements
        set_cfg(1, 3'd1, 0, 2, 0, 3, {4'd0, 4'd2, 4'd1, 4'd3});
        push_n(16, 8'h20);
        run_ev(1);

        // R4: list of 2 entries 7,12, three passes, 8-bit elements
        rnd_ready = 0;
        set_cfg(1, 3'd0, 0, 3, 0, 1, {8'h00, 4'd12, 4'd7});
        push_n(6, 8'h05);
        run_ev(1);

        // R5: 4-byte transfer size override on 8-bit elements
        set_cfg(0, 3'd0, 1, 4, 3, 0, 16'h0);
        push_n(4, 8'hA0);
        run_ev(1);

        // R6 R7: request raised before data; no acknowledge until 8 bytes buffered
        set_cfg(0, 3'd3, 0, 2, 6, 0, 16'h0);
        tgt = m_acks + 1;
        @(posedge clk);
        #1 ev_req = 1'b1;
        push_n(8, 8'h33);
        while (m_acks < tgt) @(posedge clk);
        #1 ev_req = 1'b0;
        wait_idle();

        // R6: two back-to-back events
        rnd_ready = 1;
        set_cfg(0, 3'd0, 0, 3, 11, 0, 16'h0);
        push_n(6, 8'h60);
        run_ev(2);

        // R11: empty event
        set_cfg(0, 3'd0, 0, 0, 1, 0, 16'h0);
        run_ev(1);
        chk(st_in_event == 0 && st_remain == 0, "R11 empty event", {st_in_event, st_remain}, 0);

        // R12: fill the buffer with no event, then drain it in one 64-byte event
        rnd_ready = 0;
        @(posedge clk);
        #1;
        in_valid = 1'b1;
        for (int i = 0; i < 80; i++) begin
            in_byte = 8'(i * 3 + 1);
            @(posedge clk);
            #1;
        end
        in_valid = 1'b0;
        @(negedge clk);
        chk(in_ready == 0, "R12 full buffer", in_ready, 0);
        set_cfg(0, 3'd4, 0, 8, 4, 0, 16'h0);
        run_ev(1);
        chk(st_data == 0, "R12 drained", st_data, 0);

        // R10: reserved size code
        push_n(4, 8'h11);
        set_cfg(0, 3'd5, 0, 1, 4, 0, 16'h0);
        @(posedge clk);
        #1 ev_req = 1'b1;
        repeat (3) @(posedge clk);
        #1 cfg_esize = 3'd0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(st_cfg_err == 1, "R10 sticky error", st_cfg_err, 1);
        chk(wr_valid == 0 && ev_ack == 0, "R10 no writes", {wr_valid, ev_ack}, 0);
        #1 ev_req = 1'b0;

        $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        n_checks++;
        n_err++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

endmodule